// File: doc/BRIEF.md
# SPI Four-Channel Setting Loader

This block is the serial front end of a four-channel bank of 8-bit settings. An external controller drives a chip select (active low), a serial clock and a data line. While the select is low, each rising serial clock edge moves one data bit into a 10-bit shift register. A word is sent most significant bit first: two channel address bits, then eight value bits. When the select returns high, the word now held in the register is committed. The block then pulses a one-cycle write strobe with the channel index and the value for the register bank next to it.

All three serial inputs pass through two-stage synchronisers into the system clock domain, and their edges are found there. A serial data output lets several loaders share one chip select in a chain. On each falling serial clock edge it presents the bit that leaves the top of the shift register. The output is open-drain: the block only ever asks the pad to pull the line low, and otherwise releases it.

The controller is a three-state machine. `ST_IDLE` moves to `ST_SHIFT` when the synchronised select is seen low (transition *select_low*). `ST_SHIFT` moves to `ST_COMMIT` on a synchronised select rise (transition *select_rise*). `ST_COMMIT` lasts one cycle, drives the write strobe and returns to `ST_IDLE` (transition *commit_done*).

Top module: `spi_chan_loader`

## Requirements
- R1: After reset, `wr_en_o` is low and `sdo_pull_o` is low, so the serial output line is released.
- R2: The word goes out MSB first as A1, A0, D7 … D0. On commit, `wr_chan_o` carries {A1,A0} and `wr_data_o` carries D7..D0.
- R3: Bits are taken only on rising serial clock edges while chip select is low. Serial clock activity with chip select high leaves the stored word unchanged, and it produces no write.
- R4: When more than 10 bits are clocked in one frame, only the last 10 are committed; earlier bits are discarded.
- R5: The address selects the channel index directly: 00 → index 0 (first channel), 01 → 1, 10 → 2, 11 → 3.
- R6: `sdo_pull_o` changes only after a falling serial clock edge. It then presents the inverse of the bit at the top (bit 9) of the shift register, so the line shows that bit. The line does not change on rising edges.
- R7: With two loaders chained and 20 bits clocked under one chip select, the first 10 bits are committed by the far loader and the last 10 by the near one.
- R8: A chip-select rise after fewer than 10 clocks commits the register as it stands: the older contents, moved up by the number of new bits, with the new bits at the bottom.
- R9: Each chip-select rise produces exactly one write strobe, and the strobe is exactly one system clock cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles low |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data input |
| sdo_pull_o | output | 1 | High asks the pad to pull the serial output low; low releases it |
| wr_en_o | output | 1 | One-cycle write strobe to the channel bank |
| wr_chan_o | output | ADDR_W | Channel index for the write |
| wr_data_o | output | DATA_W | Value for the write |

## Verification
Full frames are sent to each of the four addresses with different values, which shows that the address bits and the value bits are split correctly. An over-long frame and a short frame show the difference between keeping the last ten bits and keeping the first ten, and between committing the register as it stands and clearing it first. Clock pulses with the select high show whether shifting is gated by the select. The output line is sampled between each rising edge and the next falling edge, and again after the falling edge, so launching on the wrong edge is caught. A two-device chain confirms which half of a 20-bit stream lands in each device.

// File: rtl/spl_pkg.sv
package spl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } spl_state_e;

endpackage

// File: rtl/spl_sync.sv
module spl_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end
        assign q[i] = stab_q;
    end
endmodule

// File: rtl/spl_shift.sv
module spl_shift #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              launch_en,
    input  logic              sdi,
    output logic [WORD_W-1:0] word,
    output logic              sdo_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WORD_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_bit <= 1'b1;
        end else if (launch_en) begin
            sdo_bit <= word[WORD_W-1];
        end
    end
endmodule

// File: rtl/spl_ctrl.sv
module spl_ctrl
    import spl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_low,
    input  logic cs_rise,
    output logic commit
);
    spl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_low)  state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        commit = (state_q == ST_COMMIT);
    end
endmodule

// File: rtl/spi_chan_loader.sv
module spi_chan_loader #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdi_i,
    output logic              sdo_pull_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_chan_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int WORD_W = ADDR_W + DATA_W;

    logic [2:0] pins_raw, pins_s;
    logic       csn_s, sclk_s, sdi_s;
    logic       csn_q, sclk_q;
    logic       sclk_rise, sclk_fall, cs_rise, cs_low, shift_en;
    logic [WORD_W-1:0] word;
    logic       sdo_bit;

    assign pins_raw = {csn_i, sclk_i, sdi_i};

    spl_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign csn_s  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            csn_q  <= csn_s;
            sclk_q <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_rise   = csn_s & ~csn_q;
    assign cs_low    = ~csn_s;
    assign shift_en  = sclk_rise & cs_low;

    spl_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .launch_en (sclk_fall & cs_low),
        .sdi       (sdi_s),
        .word      (word),
        .sdo_bit   (sdo_bit)
    );

    spl_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_low  (cs_low),
        .cs_rise (cs_rise),
        .commit  (wr_en_o)
    );

    assign sdo_pull_o = ~sdo_bit;
    assign wr_chan_o  = word[WORD_W-1 -: ADDR_W];
    assign wr_data_o  = word[DATA_W-1:0];
endmodule

// File: rtl/spl_chk.sv
module spl_chk #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              cs_rise,
    input logic              shift_en,
    input logic              sclk_fall,
    input logic [WORD_W-1:0] word,
    input logic              sdo_pull
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R9
    AST_STROBE_FROM_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(cs_rise)); // R9
    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word) |-> $past(shift_en)); // R3
    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_pull) |-> $past(sclk_fall)); // R6
    AST_WORD_HELD_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(shift_en)); // R2
endmodule

bind spi_chan_loader spl_chk #(.WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_o),
    .cs_rise   (cs_rise),
    .shift_en  (shift_en),
    .sclk_fall (sclk_fall),
    .word      (word),
    .sdo_pull  (sdo_pull_o)
);

// File: tb/spi_chan_loader_tb_top.sv
`timescale 1ns/1ps
module spi_chan_loader_tb_top;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic n_pull, n_en, f_pull, f_en;
    logic [1:0] n_chan, f_chan;
    logic [7:0] n_data, f_data;
    logic n_line;

    int checks = 0, errors = 0;
    int n_cnt = 0, f_cnt = 0;
    logic [1:0] n_lchan, f_lchan;
    logic [7:0] n_ldata, f_ldata;
    bit done = 0;

    always #2 clk = ~clk;

    assign n_line = n_pull ? 1'b0 : 1'b1;

    spi_chan_loader dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
        .sdo_pull_o(n_pull), .wr_en_o(n_en), .wr_chan_o(n_chan), .wr_data_o(n_data));

    spi_chan_loader dut_far_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(n_line),
        .sdo_pull_o(f_pull), .wr_en_o(f_en), .wr_chan_o(f_chan), .wr_data_o(f_data));

    always @(negedge clk) begin
        if (n_en) begin n_cnt++; n_lchan = n_chan; n_ldata = n_data; end
        if (f_en) begin f_cnt++; f_lchan = f_chan; f_ldata = f_data; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_n(H);
        sclk = 1'b1;
        wait_n(H);
        sclk = 1'b0;
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        csn = 1'b0;
        wait_n(H);
        for (int i = 0; i < n; i++) send_bit(bits[n-1-i]);
        wait_n(H);
        csn = 1'b1;
        wait_n(12);
    endtask

    task automatic check_write(input string req, input int cnt0, input logic [9:0] w);
        chk(n_cnt == cnt0 + 1, {req, " R9 strobe count"}, n_cnt - cnt0, 1);
        chk(n_lchan == w[9:8], {req, " channel"}, n_lchan, w[9:8]);
        chk(n_ldata == w[7:0], {req, " data"}, n_ldata, w[7:0]);
    endtask

    task automatic t_reset;
        chk(n_en == 1'b0, "R1 wr_en after reset", n_en, 0);
        chk(n_pull == 1'b0, "R1 sdo released after reset", n_pull, 0);
        chk(f_pull == 1'b0, "R1 far sdo released after reset", f_pull, 0);
    endtask

    task automatic t_all_channels;
        for (int a = 0; a < 4; a++) begin
            int c0 = n_cnt;
            logic [9:0] w = {a[1:0], 8'h5A ^ (8'h33 * a[7:0])};
            frame({22'd0, w}, 10);
            check_write("R2 R5 channel frame", c0, w);
        end
    endtask

    task automatic t_long;
        int c0 = n_cnt;
        frame({19'd0, 3'b101, 10'h369}, 13);
        check_write("R4 last ten bits", c0, 10'h369);
    endtask

    task automatic t_short;
        int c0 = n_cnt;
        frame({28'd0, 4'b0110}, 4);
        check_write("R8 short frame", c0, 10'h296);
    endtask

    task automatic t_cs_high_clocks;
        int c0 = n_cnt;
        sdi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            wait_n(H); sclk = 1'b1; wait_n(H); sclk = 1'b0;
        end
        wait_n(12);
        chk(n_cnt == c0, "R3 no write from clocks with select high", n_cnt - c0, 0);
        frame(32'd0, 0);
        check_write("R3 word unchanged by select-high clocks", c0, 10'h296);
    endtask

    task automatic t_sdo_timing;
        logic [9:0] w1 = 10'b1010101010;
        logic [9:0] w2 = 10'b1111000011;
        int c0;
        frame({22'd0, w1}, 10);
        c0 = n_cnt;
        csn = 1'b0;
        wait_n(H);
        for (int i = 0; i < 10; i++) begin
            logic exp_after;
            sdi = w2[9-i];
            wait_n(H);
            sclk = 1'b1;
            wait_n(H - 2);
            chk(n_line == w1[9-i], "R6 line held after rising edge", n_line, w1[9-i]);
            wait_n(2);
            sclk = 1'b0;
            wait_n(H - 2);
            exp_after = (i < 9) ? w1[8-i] : w2[9];
            chk(n_line == exp_after, "R6 line after falling edge", n_line, exp_after);
            wait_n(2);
        end
        wait_n(H);
        csn = 1'b1;
        wait_n(12);
        check_write("R6 frame after output check", c0, w2);
    endtask

    task automatic t_chain;
        logic [9:0] wf = 10'h1C7;
        logic [9:0] wn = 10'h2B4;
        int fc0 = f_cnt;
        int nc0 = n_cnt;
        frame({12'd0, wf, wn}, 20);
        chk(f_cnt == fc0 + 1, "R7 far strobe count", f_cnt - fc0, 1);
        chk(f_lchan == wf[9:8], "R7 far channel", f_lchan, wf[9:8]);
        chk(f_ldata == wf[7:0], "R7 far data", f_ldata, wf[7:0]);
        check_write("R7 near", nc0, wn);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_all_channels();
        t_long();
        t_short();
        t_cs_high_clocks();
        t_sdo_timing();
        t_chain();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule